// File: doc/BRIEF.md
# Programmable Raster Sync and Blanking Generator

This block produces the horizontal sync, vertical sync and blanking signals of a raster display from a set of programmable timing values. A pixel counter runs on the video clock and restarts at the line period. A line counter advances once per line and restarts at the field length. Horizontal timing is measured in video clocks from the start of horizontal sync and is programmed with a bias of three. Vertical timing is measured in lines from the start of vertical sync and is programmed with a bias of one.

Three scan modes are supported: progressive, interlaced and interlace-repeat. In the two interlaced modes a frame consists of two fields. The second field starts its vertical sync half a line late. An optional status mode replaces the sync pins with a 2-bit window code while active window pixels are on screen. Timing values are captured at reset and at each frame boundary, so a line never mixes old and new timing.

Top module: `crt_timing_gen`

## Requirements
- R1: `pix_cnt` counts 0 up to `cfg_line_total`+2 and then wraps to 0. `line_cnt` advances when `pix_cnt` wraps, and wraps to 0 after line `cfg_frame_total`.
- R2: When status mode is not in effect, `hsync` is high exactly while `pix_cnt` < `cfg_hsync_end`+3.
- R3: `blank` is low only when `cfg_hact_begin`+3 <= `pix_cnt` < `cfg_hact_end`+3 and `cfg_vact_begin`+1 <= `line_cnt` < `cfg_vact_end`+1.
- R4: In progressive mode and in the first field of an interlaced frame, `vsync` is high exactly while `line_cnt` <= `cfg_vsync_end`. It therefore rises and falls together with a rising edge of `hsync`.
- R5: `cfg_scan_mode` encodes 00 and 01 as progressive, 10 as interlaced and 11 as interlace-repeat. In the interlaced modes the field phase starts at 0 (first field) after reset and toggles at every field wrap. In progressive mode it stays 0.
- R6: In the second field, `vsync` is delayed by floor(L/2) clocks, where L = `cfg_line_total`+3. It is high from position (line 0, pixel L/2) up to, but not including, position (line `cfg_vsync_end`+1, pixel L/2).
- R7: `field_odd` shows the field phase in mode 10. It is 0 in progressive mode and in mode 11, because the second field repeats the first.
- R8: When `cfg_win_status_en` is 1, `win_data_valid` is 1 and `blank` is low, `vsync` carries `win_status[1]` and `hsync` carries `win_status[0]`.
- R9: `vsync_start` is a one-clock pulse at the first clock of vertical sync, including the delayed start in the second field. `vblank_start` pulses at pixel 0 of line `cfg_vact_end`+1.
- R10: The timing inputs are sampled only during reset and at the last clock of a frame. In the interlaced modes that is the end of the second field. A change made elsewhere in a frame has no effect until the next frame starts.
- R11: After reset, `pix_cnt`, `line_cnt` and `field_odd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hsync_end | input | 10 | Horizontal sync width minus 3 |
| cfg_hact_begin | input | 10 | First active pixel minus 3 |
| cfg_hact_end | input | 10 | First blank pixel after the active region, minus 3 |
| cfg_line_total | input | 10 | Line period minus 3 |
| cfg_vsync_end | input | 10 | Vertical sync length in lines minus 1 |
| cfg_vact_begin | input | 10 | First active line minus 1 |
| cfg_vact_end | input | 10 | First blank line after the active region, minus 1 |
| cfg_frame_total | input | 10 | Lines per field minus 1 |
| cfg_scan_mode | input | 2 | Scan mode code |
| cfg_win_status_en | input | 1 | Enables window status on the sync pins |
| win_status | input | 2 | Window status code |
| win_data_valid | input | 1 | Window pixels are being shown |
| hsync | output | 1 | Horizontal sync, or status bit 0 |
| vsync | output | 1 | Vertical sync, or status bit 1 |
| blank | output | 1 | High outside the active area |
| field_odd | output | 1 | Second-field indicator |
| vsync_start | output | 1 | Vertical sync start pulse |
| vblank_start | output | 1 | Vertical blanking start pulse |
| line_cnt | output | 11 | Current line within the field |
| pix_cnt | output | 11 | Current clock within the line |

## Verification
The bench uses the default counter widths and programs very short rasters of 10 to 12 clocks per line and 5 to 7 lines per field. With fields this short, every clock of two or more whole frames can be compared against positions computed arithmetically from the cycle index. The odd line length of 11 exercises the rounding of the half-line delay. A timing change made during the first field of an interlaced frame shows that the old timing is kept through the second field. The window code 10, with a valid input that toggles irregularly, shows that the sync pins switch to the code only inside the active area.

// File: rtl/crt_timing_pkg.sv
package crt_timing_pkg;

    localparam int HW     = 10;
    localparam int VW     = 10;
    localparam int HCW    = HW + 1;
    localparam int VCW    = VW + 1;
    localparam int H_BIAS = 3;
    localparam int V_BIAS = 1;

    typedef enum logic [1:0] {
        SCAN_PROG    = 2'b00,
        SCAN_PROG_B  = 2'b01,
        SCAN_ILACE   = 2'b10,
        SCAN_REPEAT  = 2'b11
    } scan_mode_e;

    typedef struct packed {
        logic [HW-1:0] hsync_end;
        logic [HW-1:0] hact_begin;
        logic [HW-1:0] hact_end;
        logic [HW-1:0] line_total;
        logic [VW-1:0] vsync_end;
        logic [VW-1:0] vact_begin;
        logic [VW-1:0] vact_end;
        logic [VW-1:0] frame_total;
        scan_mode_e    mode;
    } crt_cfg_t;

    typedef struct packed {
        logic hs;
        logic hact;
        logic line_end;
    } hstate_t;

    function automatic logic is_two_field(scan_mode_e m);
        return (m == SCAN_ILACE) || (m == SCAN_REPEAT);
    endfunction

    function automatic logic [HCW-1:0] h_abs(logic [HW-1:0] x);
        return HCW'(x) + HCW'(H_BIAS);
    endfunction

    function automatic logic [VCW-1:0] v_abs(logic [VW-1:0] x);
        return VCW'(x) + VCW'(V_BIAS);
    endfunction

endpackage

// File: rtl/crt_cfg_shadow.sv
module crt_cfg_shadow
    import crt_timing_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  crt_cfg_t cfg_in,
    output crt_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/crt_h_counter.sv
module crt_h_counter
    import crt_timing_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  hsync_end,
    input  logic [HW-1:0]  hact_begin,
    input  logic [HW-1:0]  hact_end,
    input  logic [HW-1:0]  line_total,
    output logic [HCW-1:0] pix,
    output hstate_t        hst
);
    logic [HCW-1:0] last_pix;

    assign last_pix = h_abs(line_total) - HCW'(1);

    always_comb begin
        hst.line_end = (pix == last_pix);
        hst.hs       = (pix < h_abs(hsync_end));
        hst.hact     = (pix >= h_abs(hact_begin)) && (pix < h_abs(hact_end));
    end

    always_ff @(posedge clk) begin
        if (rst || hst.line_end) begin
            pix <= '0;
        end else begin
            pix <= pix + HCW'(1);
        end
    end

    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (rst)
        pix <= last_pix) else $error("pixel counter beyond line end"); // R1
endmodule

// File: rtl/crt_v_counter.sv
module crt_v_counter
    import crt_timing_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           line_end,
    input  logic [VW-1:0]  vact_begin,
    input  logic [VW-1:0]  vact_end,
    input  logic [VW-1:0]  frame_total,
    input  scan_mode_e     mode,
    output logic [VCW-1:0] line,
    output logic           phase,
    output logic           vact,
    output logic           frame_end
);
    logic field_end;
    logic two_field;
    logic seen_clk;

    assign two_field = is_two_field(mode);
    assign field_end = line_end && (line == VCW'(frame_total));
    assign frame_end = field_end && (!two_field || phase);
    assign vact      = (line >= v_abs(vact_begin)) && (line < v_abs(vact_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            line     <= '0;
            phase    <= 1'b0;
            seen_clk <= 1'b0;
        end else begin
            seen_clk <= 1'b1;
            if (field_end) begin
                line  <= '0;
                phase <= two_field ? ~phase : 1'b0;
            end else if (line_end) begin
                line  <= line + VCW'(1);
            end
        end
    end

    AST_PHASE_AT_TOP: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && (phase != $past(phase))) |-> (line == '0)) else $error("phase moved mid field"); // R5
    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && (line != $past(line))) |-> $past(line_end)) else $error("line moved mid line"); // R1
endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
    import crt_timing_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  cfg_hsync_end,
    input  logic [HW-1:0]  cfg_hact_begin,
    input  logic [HW-1:0]  cfg_hact_end,
    input  logic [HW-1:0]  cfg_line_total,
    input  logic [VW-1:0]  cfg_vsync_end,
    input  logic [VW-1:0]  cfg_vact_begin,
    input  logic [VW-1:0]  cfg_vact_end,
    input  logic [VW-1:0]  cfg_frame_total,
    input  logic [1:0]     cfg_scan_mode,
    input  logic           cfg_win_status_en,
    input  logic [1:0]     win_status,
    input  logic           win_data_valid,
    output logic           hsync,
    output logic           vsync,
    output logic           blank,
    output logic           field_odd,
    output logic           vsync_start,
    output logic           vblank_start,
    output logic [VCW-1:0] line_cnt,
    output logic [HCW-1:0] pix_cnt
);
    crt_cfg_t       cfg_in;
    crt_cfg_t       cfg;
    hstate_t        hst;
    logic           phase;
    logic           vact;
    logic           frame_end;
    logic [HCW-1:0] half;
    logic [VCW-1:0] vs_last;
    logic           vs_raw;
    logic           win_on;
    logic           seen_clk;

    always_comb begin
        cfg_in.hsync_end   = cfg_hsync_end;
        cfg_in.hact_begin  = cfg_hact_begin;
        cfg_in.hact_end    = cfg_hact_end;
        cfg_in.line_total  = cfg_line_total;
        cfg_in.vsync_end   = cfg_vsync_end;
        cfg_in.vact_begin  = cfg_vact_begin;
        cfg_in.vact_end    = cfg_vact_end;
        cfg_in.frame_total = cfg_frame_total;
        cfg_in.mode        = scan_mode_e'(cfg_scan_mode);
    end

    crt_cfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (frame_end),
        .cfg_in (cfg_in),
        .cfg_q  (cfg)
    );

    crt_h_counter u_hcnt (
        .clk        (clk),
        .rst        (rst),
        .hsync_end  (cfg.hsync_end),
        .hact_begin (cfg.hact_begin),
        .hact_end   (cfg.hact_end),
        .line_total (cfg.line_total),
        .pix        (pix_cnt),
        .hst        (hst)
    );

    crt_v_counter u_vcnt (
        .clk         (clk),
        .rst         (rst),
        .line_end    (hst.line_end),
        .vact_begin  (cfg.vact_begin),
        .vact_end    (cfg.vact_end),
        .frame_total (cfg.frame_total),
        .mode        (cfg.mode),
        .line        (line_cnt),
        .phase       (phase),
        .vact        (vact),
        .frame_end   (frame_end)
    );

    assign half    = h_abs(cfg.line_total) >> 1;
    assign vs_last = VCW'(cfg.vsync_end);

    always_comb begin
        if (phase) begin
            vs_raw = ((line_cnt == '0) && (pix_cnt >= half))
                   || ((line_cnt != '0) && (line_cnt <= vs_last))
                   || ((line_cnt == vs_last + VCW'(1)) && (pix_cnt < half));
        end else begin
            vs_raw = (line_cnt <= vs_last);
        end
    end

    assign blank        = !(hst.hact && vact);
    assign win_on       = cfg_win_status_en && win_data_valid && !blank;
    assign hsync        = win_on ? win_status[0] : hst.hs;
    assign vsync        = win_on ? win_status[1] : vs_raw;
    assign field_odd    = phase && (cfg.mode == SCAN_ILACE);
    assign vsync_start  = (line_cnt == '0) && (pix_cnt == (phase ? half : '0));
    assign vblank_start = (pix_cnt == '0) && (line_cnt == v_abs(cfg.vact_end));

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_clk <= 1'b0;
        end else begin
            seen_clk <= 1'b1;
        end
    end

    AST_WIN_CODE: assert property (@(posedge clk) disable iff (rst)
        (cfg_win_status_en && win_data_valid && !blank) |-> ({vsync, hsync} == win_status)) else $error("status code missing"); // R8
    AST_CFG_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && (cfg != $past(cfg))) |-> ((pix_cnt == '0) && (line_cnt == '0) && !phase)) else $error("timing changed mid frame"); // R10
    AST_VS_SINGLE: assert property (@(posedge clk) disable iff (rst)
        vsync_start |=> !vsync_start) else $error("sync start pulse too long"); // R9
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> ((pix_cnt == '0) && (line_cnt == '0) && !field_odd)) else $error("reset state wrong"); // R11
endmodule

// File: tb/crt_timing_gen_tb.sv
`timescale 1ns/1ps
module crt_timing_gen_tb_top;
    import crt_timing_pkg::*;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    crt_cfg_t       drv;
    logic           wen = 1'b0;
    logic [1:0]     wcode = 2'b00;
    logic           wvalid = 1'b0;
    logic           hsync, vsync, blank, field_odd, vsync_start, vblank_start;
    logic [VCW-1:0] line_cnt;
    logic [HCW-1:0] pix_cnt;
    int             nchk = 0;
    int             nerr = 0;
    bit             done = 1'b0;

    always #10 clk = ~clk;

    crt_timing_gen dut_i (
        .clk               (clk),
        .rst               (rst),
        .cfg_hsync_end     (drv.hsync_end),
        .cfg_hact_begin    (drv.hact_begin),
        .cfg_hact_end      (drv.hact_end),
        .cfg_line_total    (drv.line_total),
        .cfg_vsync_end     (drv.vsync_end),
        .cfg_vact_begin    (drv.vact_begin),
        .cfg_vact_end      (drv.vact_end),
        .cfg_frame_total   (drv.frame_total),
        .cfg_scan_mode     (drv.mode),
        .cfg_win_status_en (wen),
        .win_status        (wcode),
        .win_data_valid    (wvalid),
        .hsync             (hsync),
        .vsync             (vsync),
        .blank             (blank),
        .field_odd         (field_odd),
        .vsync_start       (vsync_start),
        .vblank_start      (vblank_start),
        .line_cnt          (line_cnt),
        .pix_cnt           (pix_cnt)
    );

    task automatic chk(string tag, string seg, int t, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s [%s] t=%0d actual=%0d expected=%0d", tag, seg, t, act, exp);
        end
    endtask

    function automatic crt_cfg_t mk(int hs, int hb, int he, int lt, int vs, int vb, int ve, int ft, int md);
        crt_cfg_t c;
        c.hsync_end   = HW'(hs);
        c.hact_begin  = HW'(hb);
        c.hact_end    = HW'(he);
        c.line_total  = HW'(lt);
        c.vsync_end   = VW'(vs);
        c.vact_begin  = VW'(vb);
        c.vact_end    = VW'(ve);
        c.frame_total = VW'(ft);
        c.mode        = scan_mode_e'(md[1:0]);
        return c;
    endfunction

    task automatic expect_at(crt_cfg_t c, int t, string seg);
        int L, F, pos, h, v, ph, half, vsn;
        logic ehs, evs, ebl, hact, vact, ewin, two;
        L    = int'(c.line_total) + 3;
        F    = int'(c.frame_total) + 1;
        two  = (c.mode == SCAN_ILACE) || (c.mode == SCAN_REPEAT);
        ph   = two ? ((t / (L * F)) % 2) : 0;
        pos  = t % (L * F);
        h    = pos % L;
        v    = pos / L;
        half = L / 2;
        vsn  = int'(c.vsync_end) + 1;
        ehs  = h < int'(c.hsync_end) + 3;
        hact = (h >= int'(c.hact_begin) + 3) && (h < int'(c.hact_end) + 3);
        vact = (v >= int'(c.vact_begin) + 1) && (v < int'(c.vact_end) + 1);
        ebl  = !(hact && vact);
        evs  = (ph == 1) ? ((pos >= half) && (pos < vsn * L + half)) : (pos < vsn * L);
        ewin = wen && wvalid && !ebl;
        chk("R1", seg, t, int'(pix_cnt), h);
        chk("R1", seg, t, int'(line_cnt), v);
        chk("R3", seg, t, int'(blank), int'(ebl));
        chk("R7", seg, t, int'(field_odd), (c.mode == SCAN_ILACE) ? ph : 0);
        chk("R9", seg, t, int'(vsync_start), int'(pos == ((ph == 1) ? half : 0)));
        chk("R9", seg, t, int'(vblank_start), int'(pos == (int'(c.vact_end) + 1) * L));
        if (ewin) begin
            chk("R8", seg, t, int'(hsync), int'(wcode[0]));
            chk("R8", seg, t, int'(vsync), int'(wcode[1]));
        end else begin
            chk("R2", seg, t, int'(hsync), int'(ehs));
            chk((ph == 1) ? "R6" : "R4", seg, t, int'(vsync), int'(evs));
        end
    endtask

    // Runs a segment from reset; c1 is driven at t_sw and expected from t_ap (R10).
    task automatic run_seg(crt_cfg_t c0, crt_cfg_t c1, int t_sw, int t_ap, int n,
                           logic we, logic [1:0] code, string seg);
        rst   = 1'b1;
        drv   = c0;
        wen   = we;
        wcode = code;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11", seg, 0, int'(pix_cnt), 0);
        chk("R11", seg, 0, int'(line_cnt), 0);
        chk("R11", seg, 0, int'(field_odd), 0);
        for (int t = 0; t < n; t++) begin
            if (t == t_sw) drv = c1;
            wvalid = ((t % 3) != 1) && ((t % 7) != 2);
            #1;
            if (t < t_ap) expect_at(c0, t, seg);
            else          expect_at(c1, t - t_ap, seg);
            @(negedge clk);
        end
    endtask

    initial begin
        crt_cfg_t ca, cb, cc, cd;
        ca = mk(0, 2, 6, 9, 0, 1, 3, 5, 1);  // code 01: progressive (R5)
        cb = mk(0, 2, 6, 9, 1, 1, 3, 5, 2);  // interlaced, L=12 (R5, R6)
        cc = mk(1, 1, 6, 8, 1, 0, 4, 6, 3);  // interlace-repeat, L=11 (R6, R7)
        cd = mk(1, 0, 5, 7, 0, 0, 2, 4, 0);  // progressive, L=10
        drv = ca;
        run_seg(ca, ca, -1, 1000000, 200, 1'b0, 2'b00, "prog01");
        run_seg(cb, cb, -1, 1000000, 300, 1'b0, 2'b00, "ilace");
        run_seg(cc, cc, -1, 1000000, 320, 1'b1, 2'b10, "repeat_win");
        run_seg(cb, cd, 10, 144, 300, 1'b0, 2'b00, "R10_change");
        run_seg(cd, ca, 37, 50, 150, 1'b1, 2'b01, "R10_prog_change");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule